// File: doc/BRIEF.md
# Iterative AES-128 Block Cipher Accelerator

This block encrypts or decrypts a single 128-bit block under a 128-bit key. Software loads the key and the input block through a small word-addressed register file, picks the direction and starts the operation. Exactly 52 clock cycles later the result replaces the input block in the data words, a done flag rises, and an interrupt line follows it if enabled.

The datapath works one 32-bit column per cycle, so each of the ten rounds takes four cycles. Round keys are produced on the fly. For decryption, the schedule is first run forward to reach the final round key. The inverse rounds then walk the schedule backward. Encryption spends those same cycles idle, so both directions take the same time.

The register file only takes full-word writes. A write with any byte lane disabled changes nothing and raises a sticky error flag.

Top module: `aes128_accel`

## Requirements
- R1: With control bit 1 clear, the operation leaves in the data words the AES-128 encryption of the block previously held there, under the key held in the key words.
- R2: With control bit 1 set, the operation leaves in the data words the AES-128 decryption of the previous block, so that decrypting a ciphertext returns its plaintext.
- R3: The done flag and the interrupt first read high exactly 52 clock edges after the edge that accepts the start write. The busy flag is high throughout that interval.
- R4: Word addresses are fixed. Word 0 is control: bit 0 is start (write-only, reads 0), bit 1 selects decrypt, bit 2 enables the interrupt. Word 1 is status: bit 0 busy, bit 1 done, bit 2 error. Words 4–7 hold the key and words 8–11 hold the data, with the lowest address carrying the most significant 32 bits. Unmapped words read 0.
- R5: A write whose byte enables are not all ones modifies no register and sets the error bit. The error bit stays set until a full write to word 1 with bit 2 set clears it.
- R6: While busy, writes to control, key and data words are ignored. A second start therefore neither restarts nor changes the direction or the result.
- R7: The done flag clears when any data word is read and when a new operation starts. Done and busy are never high together.
- R8: The interrupt output equals the done flag while the interrupt enable bit is set, and stays low while it is clear.
- R9: After reset every register reads zero and the interrupt is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word address |
| bus_be | input | 4 | Byte enables of the write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word |
| irq | output | 1 | Completion interrupt |

## Verification
The hardest case to reach from the ports is bus traffic that arrives while a block is in flight. A restart with the opposite direction and overwrites of the key and data must all land inside the 52-cycle window and still leave both the result and the timing unchanged. The stimulus does this with a directed sequence of back-to-back writes issued right after a start. The cycle count to completion is measured from the accepted start edge. Random keys and blocks from a fixed seed drive full encrypt/decrypt round trips, and each result is compared with a bench-side cipher model.

// File: rtl/aes_pkg.sv
// Package: shared sizes and the GF(2^8) arithmetic for the AES datapath.
// Assumes byte 0 of a block is its most significant byte and that columns
// are consecutive 32-bit words starting from the top.
package aes_pkg;
    localparam int WORD_W   = 32;
    localparam int BLOCK_W  = 128;
    localparam int NWORDS   = BLOCK_W / WORD_W;
    localparam int NROUNDS  = 10;
    localparam int KEY_PREP = NROUNDS;                        // forward schedule steps
    localparam int RBASE    = KEY_PREP + 2;                    // first round cycle
    localparam int LATENCY  = RBASE + NROUNDS * NWORDS;       // 52

    // multiply by x in GF(2^8)
    function automatic logic [7:0] xt(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    // general GF(2^8) product
    function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] r, p;
        r = 8'h00;
        p = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) r ^= p;
            p = xt(p);
        end
        return r;
    endfunction

    // multiplicative inverse as a^254 (0 maps to 0)
    function automatic logic [7:0] ginv(input logic [7:0] a);
        logic [7:0] r, p;
        r = 8'h01;
        p = a;
        for (int i = 0; i < 7; i++) begin
            p = gmul(p, p);
            r = gmul(r, p);
        end
        return r;
    endfunction

    function automatic logic [7:0] rotl8(input logic [7:0] a, input int n);
        logic [15:0] d;
        d = {a, a} << n;
        return d[15:8];
    endfunction

    function automatic logic [7:0] sbox(input logic [7:0] a);
        logic [7:0] b;
        b = ginv(a);
        return b ^ rotl8(b, 1) ^ rotl8(b, 2) ^ rotl8(b, 3) ^ rotl8(b, 4) ^ 8'h63;
    endfunction

    function automatic logic [7:0] isbox(input logic [7:0] a);
        return ginv(rotl8(a, 1) ^ rotl8(a, 3) ^ rotl8(a, 6) ^ 8'h05);
    endfunction

    function automatic logic [31:0] subw(input logic [31:0] w);
        return {sbox(w[31:24]), sbox(w[23:16]), sbox(w[15:8]), sbox(w[7:0])};
    endfunction

    // round constant for schedule step idx (1..NROUNDS)
    function automatic logic [7:0] rcon(input logic [3:0] idx);
        logic [7:0] r;
        r = 8'h01;
        for (int i = 1; i < NROUNDS; i++)
            if (i < int'(idx)) r = xt(r);
        return r;
    endfunction

    function automatic logic [31:0] mixc(input logic [31:0] w);
        logic [7:0] a0, a1, a2, a3;
        {a0, a1, a2, a3} = w;
        return {xt(a0) ^ xt(a1) ^ a1 ^ a2 ^ a3,
                a0 ^ xt(a1) ^ xt(a2) ^ a2 ^ a3,
                a0 ^ a1 ^ xt(a2) ^ xt(a3) ^ a3,
                xt(a0) ^ a0 ^ a1 ^ a2 ^ xt(a3)};
    endfunction

    function automatic logic [31:0] imixc(input logic [31:0] w);
        logic [7:0] a0, a1, a2, a3;
        {a0, a1, a2, a3} = w;
        return {gmul(a0,8'h0e) ^ gmul(a1,8'h0b) ^ gmul(a2,8'h0d) ^ gmul(a3,8'h09),
                gmul(a1,8'h0e) ^ gmul(a2,8'h0b) ^ gmul(a3,8'h0d) ^ gmul(a0,8'h09),
                gmul(a2,8'h0e) ^ gmul(a3,8'h0b) ^ gmul(a0,8'h0d) ^ gmul(a1,8'h09),
                gmul(a3,8'h0e) ^ gmul(a0,8'h0b) ^ gmul(a1,8'h0d) ^ gmul(a2,8'h09)};
    endfunction
endpackage

// File: rtl/aes_key_step.sv
// Key step: one AES-128 schedule step, forward (next round key) or
// backward (previous round key). Purely combinational; the caller supplies
// the round-constant index of the key being produced (forward) or held (backward).
module aes_key_step
    import aes_pkg::*;
(
    input  logic [BLOCK_W-1:0] rk,
    input  logic [3:0]         rc_idx,
    input  logic               back,
    output logic [BLOCK_W-1:0] nk
);
    logic [WORD_W-1:0] w0, w1, w2, w3, f0, f1, f2, f3, p0, p1, p2, p3;
    logic [WORD_W-1:0] rcw;

    assign {w0, w1, w2, w3} = rk;
    assign rcw = {rcon(rc_idx), 24'h0};

    // forward expansion
    always_comb begin
        f0 = w0 ^ subw({w3[23:0], w3[31:24]}) ^ rcw;
        f1 = w1 ^ f0;
        f2 = w2 ^ f1;
        f3 = w3 ^ f2;
    end

    // backward expansion
    always_comb begin
        p3 = w3 ^ w2;
        p2 = w2 ^ w1;
        p1 = w1 ^ w0;
        p0 = w0 ^ subw({p3[23:0], p3[31:24]}) ^ rcw;
    end

    assign nk = back ? {p0, p1, p2, p3} : {f0, f1, f2, f3};
endmodule

// File: rtl/aes_round_col.sv
// Round column: computes one output column of a forward or inverse round
// from the full round-input state. Assumes the state is held unchanged for
// all four columns of a round (the row shift pulls bytes from other columns).
module aes_round_col
    import aes_pkg::*;
(
    input  logic [BLOCK_W-1:0] st,
    input  logic [1:0]         col,
    input  logic               dec,
    input  logic               last,
    input  logic [WORD_W-1:0]  kw,
    output logic [WORD_W-1:0]  cw
);
    logic [WORD_W-1:0] sub_e, sub_d, t_d;

    for (genvar j = 0; j < NWORDS; j++) begin : g_row
        logic [1:0] src_e, src_d;
        assign src_e = col + 2'(j);
        assign src_d = col - 2'(j);
        // row j of this column comes from a shifted source column
        assign sub_e[8*(3-j) +: 8] = sbox (st[32*(3-int'(src_e)) + 8*(3-j) +: 8]);
        assign sub_d[8*(3-j) +: 8] = isbox(st[32*(3-int'(src_d)) + 8*(3-j) +: 8]);
    end

    assign t_d = sub_d ^ kw;

    // select the round flavour for this column
    always_comb begin
        if (!dec) cw = (last ? sub_e : mixc(sub_e)) ^ kw;
        else      cw = last ? t_d : imixc(t_d);
    end
endmodule

// File: rtl/aes_seq.sv
// Sequencer: fixed-length cycle counter that turns an accepted start into
// load, key-preparation, initial-add and round/column phases. Assumes the
// caller gates start with nothing; a start while busy is dropped here.
module aes_seq
    import aes_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    output logic       busy,
    output logic       ph_load,
    output logic       ph_kder,
    output logic       ph_init,
    output logic       ph_rnd,
    output logic       ph_fin,
    output logic [1:0] col,
    output logic       last_rnd,
    output logic [3:0] step_idx
);
    localparam int CW = $clog2(LATENCY + 1);

    logic [CW-1:0] cnt_q, off;
    logic [3:0]    rnd;

    // run counter across the fixed cycle budget
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            cnt_q <= '0;
        end else if (go && !busy) begin
            busy  <= 1'b1;
            cnt_q <= '0;
        end else if (busy) begin
            if (cnt_q == CW'(LATENCY - 1)) busy <= 1'b0;
            else                           cnt_q <= cnt_q + CW'(1);
        end
    end

    assign off      = cnt_q - CW'(RBASE);
    assign rnd      = 4'(off >> 2) + 4'd1;
    assign col      = off[1:0];
    assign ph_load  = busy && cnt_q == '0;
    assign ph_kder  = busy && cnt_q >= CW'(1) && cnt_q <= CW'(KEY_PREP);
    assign ph_init  = busy && cnt_q == CW'(KEY_PREP + 1);
    assign ph_rnd   = busy && cnt_q >= CW'(RBASE);
    assign ph_fin   = busy && cnt_q == CW'(LATENCY - 1);
    assign last_rnd = rnd == 4'(NROUNDS);
    assign step_idx = ph_kder ? 4'(cnt_q) : rnd;
endmodule

// File: rtl/aes128_accel.sv
// Top: memory-mapped AES-128 engine. Holds the register file (control,
// status, key, data), decodes the word bus, and drives the column datapath
// and key schedule from the sequencer. Assumes a single-cycle bus access
// with combinational read data; only full-word writes are honoured.
module aes128_accel
    import aes_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [3:0]  bus_addr,
    input  logic [3:0]  bus_be,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq
);
    localparam logic [3:0] A_CTRL = 4'd0;
    localparam logic [3:0] A_STAT = 4'd1;

    logic [BLOCK_W-1:0] key_q, dat_q, st_q, rk_q, key_nx;
    logic [BLOCK_W-WORD_W-1:0] nx_q;
    logic [WORD_W-1:0]  cw, kw;
    logic               dec_q, ien_q, done_q, err_q;
    logic               wr_ok, wr_bad, err_clr, go, rd_dat, ctl_wr;
    logic               busy, ph_load, ph_kder, ph_init, ph_rnd, ph_fin, last_rnd;
    logic [1:0]         col;
    logic [3:0]         step_idx, rc_idx;
    logic               is_key, is_dat;

    // bus decode
    assign wr_ok   = bus_sel && bus_wr && bus_be == 4'hF;
    assign wr_bad  = bus_sel && bus_wr && bus_be != 4'hF;
    assign is_key  = bus_addr[3:2] == 2'b01;
    assign is_dat  = bus_addr[3:2] == 2'b10;
    assign ctl_wr  = wr_ok && bus_addr == A_CTRL && !busy;
    assign go      = ctl_wr && bus_wdata[0];
    assign err_clr = wr_ok && bus_addr == A_STAT && bus_wdata[2];
    assign rd_dat  = bus_sel && !bus_wr && is_dat;

    aes_seq u_seq (
        .clk(clk), .rst_n(rst_n), .go(go), .busy(busy),
        .ph_load(ph_load), .ph_kder(ph_kder), .ph_init(ph_init), .ph_rnd(ph_rnd),
        .ph_fin(ph_fin), .col(col), .last_rnd(last_rnd), .step_idx(step_idx)
    );

    assign rc_idx = (ph_rnd && dec_q) ? 4'(NROUNDS + 1) - step_idx : step_idx;

    aes_key_step u_key (
        .rk(rk_q), .rc_idx(rc_idx), .back(ph_rnd && dec_q), .nk(key_nx)
    );

    assign kw = key_nx[32*(3-int'(col)) +: 32];

    aes_round_col u_col (
        .st(st_q), .col(col), .dec(dec_q), .last(last_rnd), .kw(kw), .cw(cw)
    );

    // key and data words: bus writes when idle, result write-back at the end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_q <= '0;
            dat_q <= '0;
        end else if (ph_fin) begin
            dat_q <= {nx_q, cw};
        end else if (wr_ok && !busy) begin
            if (is_key) key_q[32*(3-int'(bus_addr[1:0])) +: 32] <= bus_wdata;
            if (is_dat) dat_q[32*(3-int'(bus_addr[1:0])) +: 32] <= bus_wdata;
        end
    end

    // round state, partial next state and running round key
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
            nx_q <= '0;
            rk_q <= '0;
        end else if (ph_load) begin
            st_q <= dat_q;
            rk_q <= key_q;
        end else if (ph_kder) begin
            if (dec_q) rk_q <= key_nx;
        end else if (ph_init) begin
            st_q <= st_q ^ rk_q;
        end else if (ph_rnd) begin
            if (col == 2'd3) begin
                st_q <= {nx_q, cw};
                rk_q <= key_nx;
            end else begin
                nx_q[32*(2-int'(col)) +: 32] <= cw;
            end
        end
    end

    // control bits, done flag and sticky error flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_q  <= 1'b0;
            ien_q  <= 1'b0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            if (ctl_wr) begin
                dec_q <= bus_wdata[1];
                ien_q <= bus_wdata[2];
            end
            if (go)          done_q <= 1'b0;
            else if (ph_fin) done_q <= 1'b1;
            else if (rd_dat) done_q <= 1'b0;
            if (wr_bad)       err_q <= 1'b1;
            else if (err_clr) err_q <= 1'b0;
        end
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_CTRL)      bus_rdata = {29'd0, ien_q, dec_q, 1'b0};
        else if (bus_addr == A_STAT) bus_rdata = {29'd0, err_q, done_q, busy};
        else if (is_key)             bus_rdata = key_q[32*(3-int'(bus_addr[1:0])) +: 32];
        else if (is_dat)             bus_rdata = dat_q[32*(3-int'(bus_addr[1:0])) +: 32];
    end

    assign irq = done_q && ien_q;
endmodule

// File: rtl/aes128_accel_chk.sv
// Checker: timing and register-protection properties of aes128_accel,
// attached by bind. Counts busy cycles itself to check the fixed budget.
module aes128_accel_chk
    import aes_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               busy,
    input logic               done,
    input logic               err,
    input logic               err_clr,
    input logic               bus_sel,
    input logic               bus_wr,
    input logic [3:0]         bus_be,
    input logic [BLOCK_W-1:0] key
);
    logic [7:0] run_q;

    // cycles spent busy in the current operation
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) run_q <= '0;
        else                 run_q <= run_q + 8'd1;
    end

    assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> run_q == 8'(LATENCY));

    assert_done_at_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    assert_no_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && run_q < 8'(LATENCY - 1)) |=> busy);

    assert_key_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> $stable(key));

    assert_done_busy_apart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    assert_subword_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_be != 4'hF) |=> err);

    assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !err_clr) |=> err);
endmodule

bind aes128_accel aes128_accel_chk u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done_q), .err(err_q),
    .err_clr(err_clr), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_be(bus_be),
    .key(key_q)
);

// File: tb/test_aes128_accel.sv
module test_aes128_accel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0, bus_be = 4'hF;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        irq;
    int          n_chk = 0, n_err = 0, cyc = 0;
    logic [7:0]  sb [256];
    logic [7:0]  isb [256];

    aes128_accel i_aes128_accel (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // ---------------- reference model ----------------
    function automatic logic [7:0] m2(input logic [7:0] a);
        return a[7] ? ((a << 1) ^ 8'h1b) : (a << 1);
    endfunction

    function automatic logic [7:0] mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] r = 8'h00, x = a, y = b;
        while (y != 0) begin
            if (y[0]) r ^= x;
            x = m2(x);
            y = y >> 1;
        end
        return r;
    endfunction

    task automatic build_tables();
        for (int a = 0; a < 256; a++) begin
            logic [7:0] inv = 8'h00, s;
            for (int b = 1; b < 256; b++)
                if (mul(8'(a), 8'(b)) == 8'h01) inv = 8'(b);
            for (int i = 0; i < 8; i++)
                s[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8]
                     ^ inv[(i+7)%8] ^ ((8'h63 >> i) & 1);
            sb[a] = s;
            isb[s] = 8'(a);
        end
    endtask

    function automatic logic [127:0] ref_aes(input logic [127:0] key, input logic [127:0] blk,
                                             input bit decrypt);
        logic [31:0]  w [44];
        logic [127:0] rk [11];
        logic [7:0]   s [16];
        logic [7:0]   t [16];
        logic [7:0]   rc = 8'h01;
        logic [31:0]  tmp;
        logic [127:0] st;
        for (int i = 0; i < 4; i++) w[i] = key[127-32*i -: 32];
        for (int i = 4; i < 44; i++) begin
            tmp = w[i-1];
            if (i % 4 == 0) begin
                tmp = {sb[tmp[23:16]], sb[tmp[15:8]], sb[tmp[7:0]], sb[tmp[31:24]]} ^ {rc, 24'h0};
                rc = m2(rc);
            end
            w[i] = w[i-4] ^ tmp;
        end
        for (int r = 0; r < 11; r++) rk[r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
        st = blk ^ (decrypt ? rk[10] : rk[0]);
        for (int n = 1; n <= 10; n++) begin
            for (int i = 0; i < 16; i++) s[i] = st[127-8*i -: 8];
            if (!decrypt) begin
                for (int c = 0; c < 4; c++)
                    for (int j = 0; j < 4; j++) t[4*c+j] = sb[s[4*((c+j)%4)+j]];
                for (int c = 0; c < 4; c++) begin
                    logic [7:0] a0 = t[4*c], a1 = t[4*c+1], a2 = t[4*c+2], a3 = t[4*c+3];
                    if (n < 10) begin
                        t[4*c]   = mul(a0,2) ^ mul(a1,3) ^ a2 ^ a3;
                        t[4*c+1] = a0 ^ mul(a1,2) ^ mul(a2,3) ^ a3;
                        t[4*c+2] = a0 ^ a1 ^ mul(a2,2) ^ mul(a3,3);
                        t[4*c+3] = mul(a0,3) ^ a1 ^ a2 ^ mul(a3,2);
                    end
                end
                for (int i = 0; i < 16; i++) st[127-8*i -: 8] = t[i];
                st ^= rk[n];
            end else begin
                for (int c = 0; c < 4; c++)
                    for (int j = 0; j < 4; j++) t[4*c+j] = isb[s[4*((c-j+4)%4)+j]];
                for (int i = 0; i < 16; i++) t[i] ^= rk[10-n][127-8*i -: 8];
                for (int c = 0; c < 4; c++) begin
                    logic [7:0] a0 = t[4*c], a1 = t[4*c+1], a2 = t[4*c+2], a3 = t[4*c+3];
                    if (n < 10) begin
                        t[4*c]   = mul(a0,14) ^ mul(a1,11) ^ mul(a2,13) ^ mul(a3,9);
                        t[4*c+1] = mul(a0,9)  ^ mul(a1,14) ^ mul(a2,11) ^ mul(a3,13);
                        t[4*c+2] = mul(a0,13) ^ mul(a1,9)  ^ mul(a2,14) ^ mul(a3,11);
                        t[4*c+3] = mul(a0,11) ^ mul(a1,13) ^ mul(a2,9)  ^ mul(a3,14);
                    end
                end
                for (int i = 0; i < 16; i++) st[127-8*i -: 8] = t[i];
            end
        end
        return st;
    endfunction

    // ---------------- bus helpers ----------------
    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic bw(input logic [3:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_be = 4'hF;
    endtask

    task automatic br(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic load(input logic [127:0] k, input logic [127:0] d);
        for (int i = 0; i < 4; i++) bw(4'(4+i), k[127-32*i -: 32], 4'hF);
        for (int i = 0; i < 4; i++) bw(4'(8+i), d[127-32*i -: 32], 4'hF);
    endtask

    task automatic wait_irq();
        for (int g = 0; g < 200 && !irq; g++) @(negedge clk);
    endtask

    task automatic read_blk(output logic [127:0] r);
        logic [31:0] w;
        for (int i = 0; i < 4; i++) begin
            br(4'(8+i), w);
            r[127-32*i -: 32] = w;
        end
    endtask

    task automatic run_op(input logic [127:0] k, input logic [127:0] d, input bit dec,
                          output logic [127:0] res, output int lat);
        int t0;
        load(k, d);
        bw(4'd0, {29'd0, 1'b1, dec, 1'b1}, 4'hF);
        t0 = cyc;
        wait_irq();
        lat = cyc - t0;
        read_blk(res);
    endtask

    localparam logic [127:0] FK = 128'h000102030405060708090a0b0c0d0e0f;
    localparam logic [127:0] FP = 128'h00112233445566778899aabbccddeeff;
    localparam logic [127:0] FC = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [127:0] res, k, p, c;
        logic [31:0]  w;
        int           lat, t0, seed;
        build_tables();
        chk("R1 reference model self-test", ref_aes(FK, FP, 0), FC);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9 reset state
        br(4'd1, w); chk("R9 status after reset", w, 0);
        br(4'd0, w); chk("R9 control after reset", w, 0);
        br(4'd8, w); chk("R9 data after reset", w, 0);
        chk("R9 irq after reset", irq, 0);

        // R1/R3 known vector encrypt
        run_op(FK, FP, 0, res, lat);
        chk("R1 known vector encrypt", res, FC);
        chk("R3 encrypt latency", lat, 52);
        // R2 known vector decrypt
        run_op(FK, FC, 1, res, lat);
        chk("R2 known vector decrypt", res, FP);
        chk("R3 decrypt latency", lat, 52);

        // R3 exact cycle: irq low for 51 edges, high at the 52nd
        load(FK, FP);
        bw(4'd0, 32'h5, 4'hF);
        for (int e = 1; e <= 52; e++) begin
            @(negedge clk);
            if (e == 51) chk("R3 still busy at edge 51", irq, 0);
            if (e == 52) chk("R3 done at edge 52", irq, 1);
        end
        // R7 done visible, cleared by data read
        br(4'd1, w); chk("R7 status done before read", w, 32'h2);
        br(4'd9, w); chk("R4 result word 9", w, FC[95:64]);
        br(4'd1, w); chk("R7 done cleared by data read", w, 32'h0);
        chk("R8 irq follows done", irq, 0);
        br(4'd0, w); chk("R4 control readback", w, 32'h4);
        br(4'd6, w); chk("R4 key word order", w, FK[63:32]);
        br(4'd3, w); chk("R4 unmapped word reads zero", w, 0);

        // R5 sub-word write ignored and flagged
        bw(4'd4, 32'hffffffff, 4'b0011);
        br(4'd4, w); chk("R5 key word kept after halfword write", w, FK[127:96]);
        br(4'd1, w); chk("R5 error flag set", w, 32'h4);
        bw(4'd9, 32'hdeadbeef, 4'b1000);
        br(4'd9, w); chk("R5 data word kept after byte write", w, FC[95:64]);
        bw(4'd1, 32'h0, 4'hF);
        br(4'd1, w); chk("R5 error sticky without clear bit", w, 32'h4);
        bw(4'd1, 32'h4, 4'hF);
        br(4'd1, w); chk("R5 error cleared", w, 32'h0);

        // R6 writes during a running operation
        load(FK, FP);
        bw(4'd0, 32'h5, 4'hF);
        t0 = cyc;
        bw(4'd0, 32'h7, 4'hF);
        bw(4'd8, 32'h12345678, 4'hF);
        bw(4'd5, 32'hcafef00d, 4'hF);
        br(4'd1, w); chk("R3 busy bit while running", w, 32'h1);
        wait_irq();
        chk("R6 latency unchanged by restart", cyc - t0, 52);
        read_blk(res);
        chk("R6 result unchanged by busy writes", res, FC);
        br(4'd5, w); chk("R6 key write ignored while busy", w, FK[95:64]);
        br(4'd0, w); chk("R6 direction write ignored while busy", w, 32'h4);

        // R8 interrupt disabled
        load(FK, FP);
        bw(4'd0, 32'h1, 4'hF);
        repeat (60) @(negedge clk);
        chk("R8 irq low when disabled", irq, 0);
        br(4'd1, w); chk("R8 done set with irq disabled", w, 32'h2);
        read_blk(res);
        chk("R1 result with irq disabled", res, FC);

        // random round trips
        seed = $urandom(32'd2024);
        for (int n = 0; n < 10; n++) begin
            k = {$urandom, $urandom, $urandom, $urandom};
            p = {$urandom, $urandom, $urandom, $urandom};
            if (n == 0) p = '0;
            if (n == 1) k = '1;
            c = ref_aes(k, p, 0);
            run_op(k, p, 0, res, lat);
            chk("R1 random encrypt", res, c);
            run_op(k, c, 1, res, lat);
            chk("R2 random decrypt", res, p);
            chk("R3 random latency", lat, 52);
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule